// File: doc/BRIEF.md
# JTAG Pin-Sharing Enable Controller

This block decides whether four shared port pins serve as a JTAG test port or stay ordinary general-purpose I/O. Three independent sources can claim the pins, and any one of them is enough. The first is a non-volatile configuration bit that is sampled while reset is held. The second is a run-time enable bit that a microcontroller writes through a small register port. The third is a user-defined logic term. While the pins are claimed, the block routes the mode, clock and data-in pins to the TAP, holds all four pads as inputs, and turns the data-out pad around only after the TAP reports that the enabling command has arrived. The same command can also switch on the two optional status and error outputs.

Reset affects the sources differently. It always clears the run-time bit. A session held only by that bit is therefore torn down. A session held by the non-volatile bit or by the logic term keeps going through reset. A blank device samples the non-volatile bit as 1, so it comes up with the test port active.

Top module: `jpin_share_ctrl`

## Requirements
- R1: `jtag_mode_o` is 1 whenever at least one source is active: the sampled non-volatile bit, the run-time enable bit, or `pt_en_i`. `pt_en_i` takes effect in the same cycle.
- R2: While `jtag_mode_o` is 0, every pad follows the general-purpose side: `pad_oe_o`=`gpio_oe_i`, `pad_out_o`=`gpio_out_i`, `gpio_in_o`=`pad_in_i`, `pin_sel_o`=0. The TAP sees idle levels: TMS=1, TCK=0, TDI=1.
- R3: A write to address 0xC7 loads the run-time enable bit from data bit 0. Writes to other addresses leave the bit unchanged. A read at 0xC7 returns the bit in bit 0 with zeros above it. A read at any other address returns 0.
- R4: Reset clears the run-time enable bit. A session held only by that bit ends: the cycle after reset, the mode is off and the TDO pad no longer drives.
- R5: `nv_cfg_i` is sampled only while `rst` is high. Changes at other times have no effect.
- R6: If the sampled non-volatile bit is 1 or `pt_en_i` is 1, reset does not interrupt the session: the mode stays on and an enabled TDO or extension drive stays enabled.
- R7: Pads are indexed TMS=0, TCK=1, TDI=2, TDO=3. On entry to JTAG mode all four pad output-enables are 0. The TDO output-enable (`pad_oe_o[3]`) rises in the cycle after `cmd_rcvd_i` is seen with the mode on. A `cmd_rcvd_i` pulse while the mode is off is ignored.
- R8: A command accepted with `cmd_ext_i`=1 enables both extension outputs: `ext_oe_o`=2'b11 and `ext_out_o`={`terr_i`,`tstat_i`}. A command without it leaves them at 0.
- R9: When reset is released with `nv_cfg_i`=1 (the blank-device state), the JTAG mode is on with no register write.
- R10: When the mode turns off, TDO and extension drive drop in the same cycle. A later re-entry starts with the pads as inputs until a new command arrives.
- R11: In JTAG mode, `pin_sel_o`=4'hF. The TAP receives TMS, TCK and TDI from `pad_in_i[0..2]`. `pad_out_o[3]` carries `tdo_i`. `gpio_in_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_cfg_i | input | 1 | Non-volatile enable bit, sampled during reset |
| pt_en_i | input | 1 | User logic-term enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write offset |
| wr_data_i | input | DW | Register write data |
| rd_addr_i | input | AW | Register read offset |
| rd_data_o | output | DW | Register read data |
| cmd_rcvd_i | input | 1 | TAP flag: enabling command received |
| cmd_ext_i | input | 1 | The command also requests the extension pins |
| tdo_i | input | 1 | Serial data out from the TAP |
| tstat_i | input | 1 | Status level from the TAP |
| terr_i | input | 1 | Error level from the TAP |
| tap_tms_o | output | 1 | Mode select to the TAP |
| tap_tck_o | output | 1 | Test clock to the TAP |
| tap_tdi_o | output | 1 | Serial data in to the TAP |
| gpio_oe_i | input | 4 | General-purpose output-enables |
| gpio_out_i | input | 4 | General-purpose output data |
| gpio_in_o | output | 4 | Pad levels returned to general-purpose logic |
| pad_in_i | input | 4 | Pad input levels |
| pad_oe_o | output | 4 | Pad output-enables |
| pad_out_o | output | 4 | Pad output data |
| pin_sel_o | output | 4 | Per-pad select, 1 = test port |
| ext_oe_o | output | 2 | Output-enables of the status (bit 0) and error (bit 1) pins |
| ext_out_o | output | 2 | Data of the status (bit 0) and error (bit 1) pins |
| jtag_mode_o | output | 1 | Pads are claimed for the test port |

## Verification
The hardest situation to reach is a reset that lands in the middle of a live session whose owner survives reset. The session has to be fully open first, with the data-out pad turned around and the extension pins on, because only then can the bench see whether reset left it intact. The bench therefore opens the session through each source in turn, delivers the command, and then pulses reset with the non-volatile input at a chosen level. It checks the pad enables on the first cycle after reset. A second reset with the non-volatile input low confirms that a register-only session is torn down, and that re-entry starts with the data-out pad as an input.

// File: rtl/jpin_pkg.sv
package jpin_pkg;

    localparam int NPINS     = 4;
    localparam int PIN_TMS   = 0;
    localparam int PIN_TCK   = 1;
    localparam int PIN_TDI   = 2;
    localparam int PIN_TDO   = 3;
    localparam int NTAP_IN   = 3;
    localparam int NEXT_PINS = 2;

    typedef struct packed {
        logic nv;
        logic reg_bit;
        logic pterm;
    } src_t;

    typedef struct packed {
        logic tdo_drive;
        logic ext_drive;
    } sess_t;

    function automatic logic any_source(src_t s);
        return s.nv | s.reg_bit | s.pterm;
    endfunction

    function automatic logic tap_idle_level(int pin);
        return (pin == PIN_TMS) || (pin == PIN_TDI);
    endfunction

endpackage

// File: rtl/jpin_src_reg.sv
module jpin_src_reg #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] CTRL_OFFSET = 8'hC7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nv_cfg_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          nv_q_o,
    output logic          reg_en_o
);

    logic nv_q;
    logic reg_en_q;
    logic hit_wr;

    assign hit_wr = wr_en_i && (wr_addr_i == CTRL_OFFSET);

    // Non-volatile bit: captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q <= nv_cfg_i;
        end
    end

    // Run-time enable bit: cleared by reset, loaded by a matching write
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_en_q <= 1'b0;
        end else if (hit_wr) begin
            reg_en_q <= wr_data_i[0];
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == CTRL_OFFSET) begin
            rd_data_o[0] = reg_en_q;
        end
    end

    assign nv_q_o   = nv_q;
    assign reg_en_o = reg_en_q;

endmodule

// File: rtl/jpin_session.sv
module jpin_session
    import jpin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_i,
    input  logic  nv_cfg_i,
    input  logic  pt_en_i,
    input  logic  cmd_rcvd_i,
    input  logic  cmd_ext_i,
    output sess_t sess_o
);

    sess_t sess_q;
    sess_t sess_d;
    logic  keep;

    // During reset only sources that outlive reset may keep the session
    assign keep = rst ? (nv_cfg_i | pt_en_i) : 1'b1;

    always_comb begin
        sess_d = '0;
        if (mode_i && keep) begin
            sess_d.tdo_drive = sess_q.tdo_drive | cmd_rcvd_i;
            sess_d.ext_drive = sess_q.ext_drive | (cmd_rcvd_i & cmd_ext_i);
        end
    end

    always_ff @(posedge clk) begin
        sess_q <= sess_d;
    end

    assign sess_o = sess_q;

endmodule

// File: rtl/jpin_pad_slot.sv
module jpin_pad_slot
    import jpin_pkg::*;
#(
    parameter int PIN = 0
) (
    input  logic mode_i,
    input  logic tdo_drive_i,
    input  logic tdo_i,
    input  logic gpio_oe_i,
    input  logic gpio_out_i,
    input  logic pad_in_i,
    output logic gpio_in_o,
    output logic pad_oe_o,
    output logic pad_out_o,
    output logic sel_o
);

    generate
        if (PIN == PIN_TDO) begin : g_out_pin
            assign pad_oe_o  = mode_i ? tdo_drive_i : gpio_oe_i;
            assign pad_out_o = mode_i ? tdo_i       : gpio_out_i;
        end else begin : g_in_pin
            assign pad_oe_o  = mode_i ? 1'b0 : gpio_oe_i;
            assign pad_out_o = mode_i ? 1'b0 : gpio_out_i;
        end
    endgenerate

    assign gpio_in_o = mode_i ? 1'b0 : pad_in_i;
    assign sel_o     = mode_i;

endmodule

// File: rtl/jpin_share_ctrl.sv
module jpin_share_ctrl
    import jpin_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] CTRL_OFFSET = 8'hC7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nv_cfg_i,
    input  logic                 pt_en_i,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic [AW-1:0]        rd_addr_i,
    output logic [DW-1:0]        rd_data_o,
    input  logic                 cmd_rcvd_i,
    input  logic                 cmd_ext_i,
    input  logic                 tdo_i,
    input  logic                 tstat_i,
    input  logic                 terr_i,
    output logic                 tap_tms_o,
    output logic                 tap_tck_o,
    output logic                 tap_tdi_o,
    input  logic [NPINS-1:0]     gpio_oe_i,
    input  logic [NPINS-1:0]     gpio_out_i,
    output logic [NPINS-1:0]     gpio_in_o,
    input  logic [NPINS-1:0]     pad_in_i,
    output logic [NPINS-1:0]     pad_oe_o,
    output logic [NPINS-1:0]     pad_out_o,
    output logic [NPINS-1:0]     pin_sel_o,
    output logic [NEXT_PINS-1:0] ext_oe_o,
    output logic [NEXT_PINS-1:0] ext_out_o,
    output logic                 jtag_mode_o
);

    src_t              src;
    sess_t             sess;
    logic              mode;
    logic [NTAP_IN-1:0] tap_in;

    jpin_src_reg #(.AW(AW), .DW(DW), .CTRL_OFFSET(CTRL_OFFSET)) u_src_reg (
        .clk       (clk),
        .rst       (rst),
        .nv_cfg_i  (nv_cfg_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .nv_q_o    (src.nv),
        .reg_en_o  (src.reg_bit)
    );

    assign src.pterm = pt_en_i;
    assign mode      = any_source(src);

    jpin_session u_session (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .nv_cfg_i   (nv_cfg_i),
        .pt_en_i    (pt_en_i),
        .cmd_rcvd_i (cmd_rcvd_i),
        .cmd_ext_i  (cmd_ext_i),
        .sess_o     (sess)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pad
        jpin_pad_slot #(.PIN(p)) u_slot (
            .mode_i      (mode),
            .tdo_drive_i (sess.tdo_drive),
            .tdo_i       (tdo_i),
            .gpio_oe_i   (gpio_oe_i[p]),
            .gpio_out_i  (gpio_out_i[p]),
            .pad_in_i    (pad_in_i[p]),
            .gpio_in_o   (gpio_in_o[p]),
            .pad_oe_o    (pad_oe_o[p]),
            .pad_out_o   (pad_out_o[p]),
            .sel_o       (pin_sel_o[p])
        );
    end

    for (genvar t = 0; t < NTAP_IN; t++) begin : g_tap_in
        assign tap_in[t] = mode ? pad_in_i[t] : tap_idle_level(t);
    end

    assign tap_tms_o = tap_in[PIN_TMS];
    assign tap_tck_o = tap_in[PIN_TCK];
    assign tap_tdi_o = tap_in[PIN_TDI];

    assign ext_oe_o  = {NEXT_PINS{mode & sess.ext_drive}};
    assign ext_out_o = {terr_i, tstat_i} & ext_oe_o;

    assign jtag_mode_o = mode;

endmodule

// File: rtl/jpin_share_ctrl_chk.sv
module jpin_share_ctrl_chk #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] CTRL_OFFSET = 8'hC7
) (
    input logic          clk,
    input logic          rst,
    input logic          nv_cfg_i,
    input logic          pt_en_i,
    input logic          cmd_rcvd_i,
    input logic [AW-1:0] rd_addr_i,
    input logic [DW-1:0] rd_data_o,
    input logic [3:0]    gpio_oe_i,
    input logic [3:0]    pad_oe_o,
    input logic [1:0]    ext_oe_o,
    input logic          jtag_mode_o
);

    // R1: the logic term alone claims the pads
    a_r1_pterm_claims: assert property (@(posedge clk) disable iff (rst)
        pt_en_i |-> jtag_mode_o);

    // R2: released pads follow the general-purpose enables
    a_r2_gpio_oe_pass: assert property (@(posedge clk) disable iff (rst)
        !jtag_mode_o |-> (pad_oe_o == gpio_oe_i));

    // R4: register bit reads back clear right after reset
    a_r4_reg_cleared: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && rd_addr_i == CTRL_OFFSET) |-> (rd_data_o == '0));

    // R4: a register-only session does not survive reset
    a_r4_session_ends: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && !$past(nv_cfg_i) && !pt_en_i) |-> !jtag_mode_o);

    // R6: a non-volatile claim survives reset
    a_r6_nv_survives: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && $past(nv_cfg_i)) |-> jtag_mode_o);

    // R7: pads start as inputs on entry
    a_r7_inputs_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(jtag_mode_o) |-> (pad_oe_o == 4'b0000));

    // R7: accepted command turns the data-out pad around next cycle
    a_r7_tdo_after_cmd: assert property (@(posedge clk) disable iff (rst)
        (jtag_mode_o && cmd_rcvd_i) |=> (pad_oe_o[3] || !jtag_mode_o));

    // R10: extension pins are quiet whenever the pads are released
    a_r10_ext_quiet: assert property (@(posedge clk) disable iff (rst)
        !jtag_mode_o |-> (ext_oe_o == 2'b00));

endmodule

bind jpin_share_ctrl jpin_share_ctrl_chk #(.AW(AW), .DW(DW), .CTRL_OFFSET(CTRL_OFFSET)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nv_cfg_i    (nv_cfg_i),
    .pt_en_i     (pt_en_i),
    .cmd_rcvd_i  (cmd_rcvd_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .gpio_oe_i   (gpio_oe_i),
    .pad_oe_o    (pad_oe_o),
    .ext_oe_o    (ext_oe_o),
    .jtag_mode_o (jtag_mode_o)
);

// File: tb/jpin_share_ctrl_bench.sv
`timescale 1ns/1ps
module jpin_share_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nv_cfg_i = 1'b1;
    logic       pt_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_addr_i = 8'hC7;
    logic [7:0] rd_data_o;
    logic       cmd_rcvd_i = 1'b0;
    logic       cmd_ext_i = 1'b0;
    logic       tdo_i = 1'b0;
    logic       tstat_i = 1'b0;
    logic       terr_i = 1'b0;
    logic       tap_tms_o, tap_tck_o, tap_tdi_o;
    logic [3:0] gpio_oe_i = 4'b0000;
    logic [3:0] gpio_out_i = 4'b0000;
    logic [3:0] gpio_in_o;
    logic [3:0] pad_in_i = 4'b0000;
    logic [3:0] pad_oe_o, pad_out_o, pin_sel_o;
    logic [1:0] ext_oe_o, ext_out_o;
    logic       jtag_mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    jpin_share_ctrl u_jpin_share_ctrl (
        .clk, .rst, .nv_cfg_i, .pt_en_i, .wr_en_i, .wr_addr_i, .wr_data_i,
        .rd_addr_i, .rd_data_o, .cmd_rcvd_i, .cmd_ext_i, .tdo_i, .tstat_i,
        .terr_i, .tap_tms_o, .tap_tck_o, .tap_tdi_o, .gpio_oe_i, .gpio_out_i,
        .gpio_in_o, .pad_in_i, .pad_oe_o, .pad_out_o, .pin_sel_o, .ext_oe_o,
        .ext_out_o, .jtag_mode_o
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic nv);
        rst = 1'b1;
        nv_cfg_i = nv;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic send_cmd(logic ext);
        cmd_rcvd_i = 1'b1; cmd_ext_i = ext;
        #1;
        check("R7 oe before cmd edge", {7'b0, pad_oe_o[3]}, 8'h00);
        tick();
        cmd_rcvd_i = 1'b0; cmd_ext_i = 1'b0;
    endtask

    // R9: blank default claims the pads
    task automatic t_blank();
        do_reset(1'b1);
        check("R9 blank mode", {7'b0, jtag_mode_o}, 8'h01);
        check("R7 entry all inputs", {4'b0, pad_oe_o}, 8'h00);
        check("R11 sel", {4'b0, pin_sel_o}, 8'h0F);
        check("R11 gpio_in zero", {4'b0, gpio_in_o}, 8'h00);
    endtask

    // R2: released pads follow gpio
    task automatic t_released();
        do_reset(1'b0);
        gpio_oe_i = 4'b1010; gpio_out_i = 4'b0110; pad_in_i = 4'b1001;
        #1;
        check("R2 mode off", {7'b0, jtag_mode_o}, 8'h00);
        check("R2 oe", {4'b0, pad_oe_o}, 8'h0A);
        check("R2 out", {4'b0, pad_out_o}, 8'h06);
        check("R2 in", {4'b0, gpio_in_o}, 8'h09);
        check("R2 sel", {4'b0, pin_sel_o}, 8'h00);
        check("R2 tap idle", {5'b0, tap_tms_o, tap_tck_o, tap_tdi_o}, 8'h05);
        check("R3 readback zero", rd_data_o, 8'h00);
    endtask

    // R3, R4, R7, R10, R11: register source
    task automatic t_reg_source();
        reg_write(8'hC6, 8'hFF);
        check("R3 other offset ignored", {7'b0, jtag_mode_o}, 8'h00);
        check("R3 other offset readback", rd_data_o, 8'h00);
        reg_write(8'hC7, 8'h01);
        check("R1 reg source", {7'b0, jtag_mode_o}, 8'h01);
        check("R3 readback one", rd_data_o, 8'h01);
        rd_addr_i = 8'h10; #1;
        check("R3 other read zero", rd_data_o, 8'h00);
        rd_addr_i = 8'hC7;
        check("R7 entry inputs", {4'b0, pad_oe_o}, 8'h00);
        send_cmd(1'b0);
        check("R7 tdo oe after cmd", {4'b0, pad_oe_o}, 8'h08);
        check("R8 ext off without request", {6'b0, ext_oe_o}, 8'h00);
        pad_in_i = 4'b0010; tdo_i = 1'b1; #1;
        check("R11 tap inputs", {5'b0, tap_tms_o, tap_tck_o, tap_tdi_o}, 8'h02);
        check("R11 tdo out", {7'b0, pad_out_o[3]}, 8'h01);
        do_reset(1'b0);
        check("R4 mode off after reset", {7'b0, jtag_mode_o}, 8'h00);
        check("R4 tdo follows gpio", {7'b0, pad_oe_o[3]}, {7'b0, gpio_oe_i[3]});
        check("R4 reg cleared", rd_data_o, 8'h00);
        reg_write(8'hC7, 8'h01);
        check("R10 reentry tdo input", {4'b0, pad_oe_o}, 8'h00);
        reg_write(8'hC7, 8'h00);
        check("R3 write clears", {7'b0, jtag_mode_o}, 8'h00);
    endtask

    // R7: command while released is ignored
    task automatic t_cmd_off();
        cmd_rcvd_i = 1'b1; cmd_ext_i = 1'b1;
        tick();
        cmd_rcvd_i = 1'b0; cmd_ext_i = 1'b0;
        reg_write(8'hC7, 8'h01);
        check("R7 cmd while off ignored", {4'b0, pad_oe_o}, 8'h00);
        check("R7 ext ignored", {6'b0, ext_oe_o}, 8'h00);
        reg_write(8'hC7, 8'h00);
    endtask

    // R1, R6, R8, R10: logic-term source
    task automatic t_pt_source();
        pt_en_i = 1'b1; #1;
        check("R1 pt same cycle", {7'b0, jtag_mode_o}, 8'h01);
        send_cmd(1'b1);
        tstat_i = 1'b1; terr_i = 1'b0; #1;
        check("R8 ext oe", {6'b0, ext_oe_o}, 8'h03);
        check("R8 ext out", {6'b0, ext_out_o}, 8'h01);
        do_reset(1'b0);
        check("R6 pt survives reset", {7'b0, jtag_mode_o}, 8'h01);
        check("R6 tdo kept", {7'b0, pad_oe_o[3]}, 8'h01);
        check("R6 ext kept", {6'b0, ext_oe_o}, 8'h03);
        pt_en_i = 1'b0; #1;
        check("R10 ext drops", {6'b0, ext_oe_o}, 8'h00);
        check("R10 tdo drops", {7'b0, pad_oe_o[3]}, {7'b0, gpio_oe_i[3]});
        tick();
        pt_en_i = 1'b1; #1;
        check("R10 session forgotten", {4'b0, pad_oe_o}, 8'h00);
        pt_en_i = 1'b0;
        tstat_i = 1'b0;
    endtask

    // R5, R6: non-volatile source
    task automatic t_nv_source();
        do_reset(1'b1);
        nv_cfg_i = 1'b0;
        tick();
        check("R5 nv change ignored", {7'b0, jtag_mode_o}, 8'h01);
        send_cmd(1'b0);
        reg_write(8'hC7, 8'h00);
        check("R1 nv holds without reg", {7'b0, jtag_mode_o}, 8'h01);
        do_reset(1'b1);
        check("R6 nv tdo kept", {4'b0, pad_oe_o}, 8'h08);
        do_reset(1'b0);
        check("R4 nv cleared releases", {7'b0, jtag_mode_o}, 8'h00);
        nv_cfg_i = 1'b1;
        tick();
        tick();
        check("R5 nv rise ignored", {7'b0, jtag_mode_o}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        t_blank();
        t_released();
        t_reg_source();
        t_cmd_off();
        t_pt_source();
        t_nv_source();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule